// File: doc/BRIEF.md
# CAN fault confinement error counters

This block keeps the two fault confinement counters of a CAN node, one for transmission and one for reception, and derives from them which of the three confinement states the node is in: error-active, error-passive or bus-off. It does no bit timing, frame decoding or error detection of its own. The protocol engine around it reports what happened on the bus as single-cycle event pulses, and the block turns those pulses into counter updates and status flags.

The transmit counter is 9 bits wide, so that it can go past 255 and signal bus-off. Software sees only its low byte. The receive counter is 8 bits wide, saturates at 255, and drops straight to 120 after a good frame whenever it stands above 128. Once the node is in bus-off, both counters stay frozen until a recovery pulse clears them.

The block also holds a small diagnosis byte. It has two mode bits that software can write (silent and loop back), a registered copy of the live receive pin, and the bus level captured at the most recent sample point.

Top module: `can_fault_counters`

## Requirements
- R1: Reset clears both counters and both mode bits and sets error-active. The diagnosis byte then reads 0x00 once the receive pin and the sample bit are low.
- R2: A transmit error in either form (tx_err_normal or tx_err_severe) raises the transmit counter by 8. A successful transmission lowers it by 1 and leaves it at 0 when it is already 0.
- R3: A normal receive error raises the receive counter by 1 and a severe one raises it by 8. The result saturates at 255. When both forms arrive together, only the severe step applies.
- R4: After a successful reception, the receive counter is loaded with 120 if it is above 128. Otherwise it drops by 1, and it stays at 0 if it is already 0.
- R5: If an increment event and a decrement event for the same counter arrive in the same cycle, only the increment applies.
- R6: Outside bus-off, err_passive is high when either counter is above 127, and err_active is high when both are 127 or less. Exactly one of the three status flags is high at any time after reset.
- R7: The node enters bus-off in the same cycle the transmit counter goes above 255. While it is in bus-off, all counter events are ignored. A busoff_recover pulse during bus-off clears both counters and returns the node to error-active. A recovery pulse outside bus-off has no effect.
- R8: tec_byte always shows bits 7:0 of the 9-bit transmit counter, including while the node is in bus-off. rec_byte shows the full receive counter.
- R9: A write with diag_we loads diag_wr_mode[1] into the silent bit (diagnosis bit 1) and diag_wr_mode[0] into the loop back bit (diagnosis bit 0). Diagnosis bits 7 to 4 always read 0.
- R10: Diagnosis bit 3 shows the receive pin level registered one cycle earlier. Diagnosis bit 2 holds the sample bit captured at the last sample_strobe and keeps its value between strobes.
- R11: Counters and flags are registered, and each event takes effect at the first clock edge where it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_err_normal | input | 1 | Transmit error pulse, normal form |
| tx_err_severe | input | 1 | Transmit error pulse, severe form |
| tx_ok | input | 1 | Successful transmission pulse |
| rx_err_normal | input | 1 | Receive error pulse, step 1 |
| rx_err_severe | input | 1 | Receive error pulse, step 8 |
| rx_ok | input | 1 | Successful reception pulse |
| busoff_recover | input | 1 | Bus-off recovery pulse |
| rx_pin | input | 1 | Live receive pin level |
| sample_bit | input | 1 | Bus level at the current sample point |
| sample_strobe | input | 1 | Marks a sample point |
| diag_we | input | 1 | Mode bit write strobe |
| diag_wr_mode | input | 2 | Mode bits to write: [1] silent, [0] loop back |
| tec_byte | output | 8 | Low byte of the transmit counter |
| rec_byte | output | 8 | Receive counter |
| err_active | output | 1 | Node is error-active |
| err_passive | output | 1 | Node is error-passive |
| bus_off | output | 1 | Node is in bus-off |
| diag_rdata | output | 8 | Diagnosis byte: 0,0,0,0,pin,sample,silent,loop back |
| silent_mode | output | 1 | Silent mode bit |
| loopback_mode | output | 1 | Loop back mode bit |

## Verification
The step assertions assume the default step sizes. Under those defaults the transmit counter cannot overflow its 9 bits before it freezes in bus-off, because the highest value it can reach is 255 + 8. The assertions also treat every event input as a free pulse, so they put no limit on how events combine within one cycle. The stimulus matches that. It reaches each receive counter value from 0 to 255 and each transmit counter value from 0 to 263 using only legal event sequences. It then drives long pseudo-random streams, which include simultaneous increments and decrements and recovery pulses both inside and outside bus-off, and compares every cycle against an arithmetic model.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;
endpackage

// File: rtl/can_fc_tx_counter.sv
module can_fc_tx_counter #(
  parameter int W        = 9,
  parameter int STEP     = 8,
  parameter int SEV_STEP = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         err_n,
  input  logic         err_s,
  input  logic         ok,
  input  logic         freeze,
  input  logic         clear,
  output logic [W-1:0] tec_q,
  output logic [W-1:0] tec_d
);
  localparam int WX = W + 1;
  localparam logic [W:0] STEP_V = WX'(STEP);
  localparam logic [W:0] SEV_V  = WX'(SEV_STEP);

  logic [W:0] sum;

  always_comb begin
    sum   = {1'b0, tec_q} + (err_s ? SEV_V : STEP_V);
    tec_d = tec_q;
    if (clear) begin
      tec_d = '0;
    end else if (!freeze) begin
      if (err_n || err_s) begin
        tec_d = sum[W] ? '1 : sum[W-1:0];
      end else if (ok && (tec_q != '0)) begin
        tec_d = tec_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tec_q <= '0;
    else     tec_q <= tec_d;
  end

  // R2 / R5: an error adds the step, even with a success in the same cycle
  p_tec_step_r2: assert property (@(posedge clk) disable iff (rst)
    (err_n && !err_s && !freeze && !clear) |=> (tec_q == $past(tec_q) + W'(STEP)));
  p_tec_inc_wins_r5: assert property (@(posedge clk) disable iff (rst)
    ((err_n || err_s) && ok && !freeze && !clear) |=> (tec_q > $past(tec_q)));
  p_tec_floor_r2: assert property (@(posedge clk) disable iff (rst)
    (ok && !err_n && !err_s && !clear && (tec_q == '0)) |=> (tec_q == '0));
  p_tec_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (freeze && !clear) |=> $stable(tec_q));
endmodule

// File: rtl/can_fc_rx_counter.sv
module can_fc_rx_counter #(
  parameter int W         = 8,
  parameter int STEP      = 1,
  parameter int SEV_STEP  = 8,
  parameter int RELOAD    = 120,
  parameter int RELOAD_GT = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         err_n,
  input  logic         err_s,
  input  logic         ok,
  input  logic         freeze,
  input  logic         clear,
  output logic [W-1:0] rec_q,
  output logic [W-1:0] rec_d
);
  localparam int WX = W + 1;
  localparam logic [W:0]   STEP_V   = WX'(STEP);
  localparam logic [W:0]   SEV_V    = WX'(SEV_STEP);
  localparam logic [W-1:0] RELOAD_V = W'(RELOAD);
  localparam logic [W-1:0] GT_V     = W'(RELOAD_GT);

  logic [W:0] sum;

  always_comb begin
    sum   = {1'b0, rec_q} + (err_s ? SEV_V : STEP_V);
    rec_d = rec_q;
    if (clear) begin
      rec_d = '0;
    end else if (!freeze) begin
      if (err_n || err_s) begin
        rec_d = sum[W] ? '1 : sum[W-1:0];
      end else if (ok) begin
        if (rec_q > GT_V)       rec_d = RELOAD_V;
        else if (rec_q != '0)   rec_d = rec_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rec_q <= '0;
    else     rec_q <= rec_d;
  end

  p_rec_saturate_r3: assert property (@(posedge clk) disable iff (rst)
    ((rec_q == '1) && (err_n || err_s) && !freeze && !clear) |=> (rec_q == '1));
  p_rec_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (ok && !err_n && !err_s && !freeze && !clear && (rec_q > GT_V)) |=> (rec_q == RELOAD_V));
  p_rec_inc_wins_r5: assert property (@(posedge clk) disable iff (rst)
    ((err_n || err_s) && ok && !freeze && !clear && (rec_q != '1)) |=> (rec_q > $past(rec_q)));
  p_rec_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (freeze && !clear) |=> $stable(rec_q));
endmodule

// File: rtl/can_fc_state.sv
module can_fc_state
  import can_fc_pkg::*;
#(
  parameter int TEC_W      = 9,
  parameter int REC_W      = 8,
  parameter int PASSIVE_AT = 128,
  parameter int BUSOFF_AT  = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TEC_W-1:0] tec_d,
  input  logic [REC_W-1:0] rec_d,
  input  logic             recover,
  output logic             active_q,
  output logic             passive_q,
  output logic             busoff_q
);
  localparam logic [TEC_W-1:0] TEC_PASS_V = TEC_W'(PASSIVE_AT);
  localparam logic [TEC_W-1:0] TEC_OFF_V  = TEC_W'(BUSOFF_AT);
  localparam logic [REC_W-1:0] REC_PASS_V = REC_W'(PASSIVE_AT);

  fc_state_e state_q, state_d;

  always_comb begin
    if (state_q == FC_BUSOFF)          state_d = recover ? FC_ACTIVE : FC_BUSOFF;
    else if (tec_d >= TEC_OFF_V)       state_d = FC_BUSOFF;
    else if ((tec_d >= TEC_PASS_V) || (rec_d >= REC_PASS_V))
                                       state_d = FC_PASSIVE;
    else                               state_d = FC_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= FC_ACTIVE;
      active_q  <= 1'b1;
      passive_q <= 1'b0;
      busoff_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      active_q  <= (state_d == FC_ACTIVE);
      passive_q <= (state_d == FC_PASSIVE);
      busoff_q  <= (state_d == FC_BUSOFF);
    end
  end

  p_one_flag_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot({active_q, passive_q, busoff_q}));
  p_busoff_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (busoff_q && !recover) |=> busoff_q);
endmodule

// File: rtl/can_fc_diag.sv
module can_fc_diag #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_pin,
  input  logic              sample_bit,
  input  logic              sample_strobe,
  input  logic              we,
  input  logic [1:0]        wr_mode,
  output logic [BYTE_W-1:0] rdata,
  output logic              silent_q,
  output logic              loop_q
);
  localparam int PAD_W = BYTE_W - 4;

  logic pin_q, samp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q    <= 1'b0;
      samp_q   <= 1'b0;
      silent_q <= 1'b0;
      loop_q   <= 1'b0;
    end else begin
      pin_q <= rx_pin;
      if (sample_strobe) samp_q <= sample_bit;
      if (we) begin
        silent_q <= wr_mode[1];
        loop_q   <= wr_mode[0];
      end
    end
  end

  assign rdata = {{PAD_W{1'b0}}, pin_q, samp_q, silent_q, loop_q};

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable({silent_q, loop_q}));
  p_sample_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !sample_strobe |=> $stable(samp_q));
  p_pin_follow_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_q == $past(rx_pin)));
endmodule

// File: rtl/can_fault_counters.sv
module can_fault_counters #(
  parameter int TEC_W          = 9,
  parameter int REC_W          = 8,
  parameter int BYTE_W         = 8,
  parameter int TX_STEP        = 8,
  parameter int TX_SEVERE_STEP = 8,
  parameter int RX_STEP        = 1,
  parameter int RX_SEVERE_STEP = 8,
  parameter int PASSIVE_AT     = 128,
  parameter int BUSOFF_AT      = 256,
  parameter int REC_RELOAD     = 120
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_err_normal,
  input  logic              tx_err_severe,
  input  logic              tx_ok,
  input  logic              rx_err_normal,
  input  logic              rx_err_severe,
  input  logic              rx_ok,
  input  logic              busoff_recover,
  input  logic              rx_pin,
  input  logic              sample_bit,
  input  logic              sample_strobe,
  input  logic              diag_we,
  input  logic [1:0]        diag_wr_mode,
  output logic [BYTE_W-1:0] tec_byte,
  output logic [REC_W-1:0]  rec_byte,
  output logic              err_active,
  output logic              err_passive,
  output logic              bus_off,
  output logic [BYTE_W-1:0] diag_rdata,
  output logic              silent_mode,
  output logic              loopback_mode
);
  localparam int REC_RELOAD_GT = PASSIVE_AT;
  localparam logic [TEC_W-1:0] TEC_PASS_V = TEC_W'(PASSIVE_AT);
  localparam logic [REC_W-1:0] REC_PASS_V = REC_W'(PASSIVE_AT);

  logic [TEC_W-1:0] tec_q, tec_d;
  logic [REC_W-1:0] rec_q, rec_d;
  logic             clear;

  assign clear = bus_off & busoff_recover;

  can_fc_tx_counter #(.W(TEC_W), .STEP(TX_STEP), .SEV_STEP(TX_SEVERE_STEP)) u_tx (
    .clk(clk), .rst(rst), .err_n(tx_err_normal), .err_s(tx_err_severe), .ok(tx_ok),
    .freeze(bus_off), .clear(clear), .tec_q(tec_q), .tec_d(tec_d)
  );

  can_fc_rx_counter #(.W(REC_W), .STEP(RX_STEP), .SEV_STEP(RX_SEVERE_STEP),
                      .RELOAD(REC_RELOAD), .RELOAD_GT(REC_RELOAD_GT)) u_rx (
    .clk(clk), .rst(rst), .err_n(rx_err_normal), .err_s(rx_err_severe), .ok(rx_ok),
    .freeze(bus_off), .clear(clear), .rec_q(rec_q), .rec_d(rec_d)
  );

  can_fc_state #(.TEC_W(TEC_W), .REC_W(REC_W), .PASSIVE_AT(PASSIVE_AT),
                 .BUSOFF_AT(BUSOFF_AT)) u_state (
    .clk(clk), .rst(rst), .tec_d(tec_d), .rec_d(rec_d), .recover(busoff_recover),
    .active_q(err_active), .passive_q(err_passive), .busoff_q(bus_off)
  );

  can_fc_diag #(.BYTE_W(BYTE_W)) u_diag (
    .clk(clk), .rst(rst), .rx_pin(rx_pin), .sample_bit(sample_bit),
    .sample_strobe(sample_strobe), .we(diag_we), .wr_mode(diag_wr_mode),
    .rdata(diag_rdata), .silent_q(silent_mode), .loop_q(loopback_mode)
  );

  assign tec_byte = tec_q[BYTE_W-1:0];
  assign rec_byte = rec_q;

  p_recover_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_off && busoff_recover) |=> ((tec_q == '0) && (rec_q == '0) && err_active));
  p_recover_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (!bus_off && busoff_recover && !tx_err_normal && !tx_err_severe && !tx_ok
     && !rx_err_normal && !rx_err_severe && !rx_ok) |=> ($stable(tec_q) && $stable(rec_q)));
  p_passive_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (!bus_off && ((tec_q >= TEC_PASS_V) || (rec_q >= REC_PASS_V))) |-> err_passive);
  p_active_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (!bus_off && (tec_q < TEC_PASS_V) && (rec_q < REC_PASS_V)) |-> err_active);
endmodule

// File: tb/can_fault_counters_bench.sv
`timescale 1ns/1ps
module can_fault_counters_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_err_normal = 0, tx_err_severe = 0, tx_ok = 0;
  logic rx_err_normal = 0, rx_err_severe = 0, rx_ok = 0;
  logic busoff_recover = 0, rx_pin = 0, sample_bit = 0, sample_strobe = 0, diag_we = 0;
  logic [1:0] diag_wr_mode = 2'b00;
  logic [7:0] tec_byte, rec_byte, diag_rdata;
  logic err_active, err_passive, bus_off, silent_mode, loopback_mode;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  int exp_tec = 0, exp_rec = 0;
  bit exp_off = 0;

  always #2.5 clk = ~clk;

  can_fault_counters u_can_fault_counters (
    .clk(clk), .rst(rst), .tx_err_normal(tx_err_normal), .tx_err_severe(tx_err_severe),
    .tx_ok(tx_ok), .rx_err_normal(rx_err_normal), .rx_err_severe(rx_err_severe),
    .rx_ok(rx_ok), .busoff_recover(busoff_recover), .rx_pin(rx_pin),
    .sample_bit(sample_bit), .sample_strobe(sample_strobe), .diag_we(diag_we),
    .diag_wr_mode(diag_wr_mode), .tec_byte(tec_byte), .rec_byte(rec_byte),
    .err_active(err_active), .err_passive(err_passive), .bus_off(bus_off),
    .diag_rdata(diag_rdata), .silent_mode(silent_mode), .loopback_mode(loopback_mode)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    bit pas;
    pas = !exp_off && (exp_tec > 127 || exp_rec > 127);
    chk(req, "tec_byte", int'(tec_byte), exp_tec % 256);
    chk(req, "rec_byte", int'(rec_byte), exp_rec);
    chk(req, "bus_off", int'(bus_off), int'(exp_off));
    chk(req, "err_passive", int'(err_passive), int'(pas));
    chk(req, "err_active", int'(err_active), int'(!exp_off && !pas));
  endtask

  // Reference model of one clock edge (R2..R7)
  task automatic model(input bit tn, ts, tk, rn, rs, rk, rc);
    if (exp_off) begin
      if (rc) begin exp_tec = 0; exp_rec = 0; exp_off = 0; end
    end else begin
      if (tn || ts) exp_tec = exp_tec + 8;
      else if (tk && exp_tec > 0) exp_tec = exp_tec - 1;
      if (rs) exp_rec = (exp_rec + 8 > 255) ? 255 : exp_rec + 8;
      else if (rn) exp_rec = (exp_rec + 1 > 255) ? 255 : exp_rec + 1;
      else if (rk) exp_rec = (exp_rec > 128) ? 120 : ((exp_rec > 0) ? exp_rec - 1 : 0);
      if (exp_tec > 255) exp_off = 1;
    end
  endtask

  // Called at a negative edge: drive, clock once, sample at the next negative edge
  task automatic ev(input bit tn, ts, tk, rn, rs, rk, rc);
    tx_err_normal = tn; tx_err_severe = ts; tx_ok = tk;
    rx_err_normal = rn; rx_err_severe = rs; rx_ok = rk; busoff_recover = rc;
    @(posedge clk);
    model(tn, ts, tk, rn, rs, rk, rc);
    @(negedge clk);
    tx_err_normal = 0; tx_err_severe = 0; tx_ok = 0;
    rx_err_normal = 0; rx_err_severe = 0; rx_ok = 0; busoff_recover = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    exp_tec = 0; exp_rec = 0; exp_off = 0;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check_all("R1");
    chk("R1", "diag_rdata", int'(diag_rdata), 0);
    chk("R1", "mode bits", int'({silent_mode, loopback_mode}), 0);

    // R11 single event lands at the first edge
    ev(1, 0, 0, 0, 0, 0, 0);
    check_all("R11 R2");
    ev(0, 1, 0, 0, 0, 0, 0);
    check_all("R2 severe");
    ev(0, 0, 0, 1, 1, 0, 0);
    check_all("R3 both forms");
    ev(1, 0, 1, 0, 0, 0, 0);
    check_all("R5 tx");
    ev(0, 0, 0, 1, 0, 1, 0);
    check_all("R5 rx");
    ev(0, 0, 0, 0, 0, 0, 1);
    check_all("R7 recover outside bus-off");

    // R4 / R6 sweep over every receive counter value
    for (int v = 0; v < 256; v++) begin
      do_reset();
      for (int k = 0; k < v / 8; k++) ev(0, 0, 0, 0, 1, 0, 0);
      for (int k = 0; k < v % 8; k++) ev(0, 0, 0, 1, 0, 0, 0);
      chk("R3", "rec reach", int'(rec_byte), v);
      check_all("R6");
      ev(0, 0, 0, 0, 0, 1, 0);
      chk("R4", "rec after success", int'(rec_byte), (v > 128) ? 120 : ((v > 0) ? v - 1 : 0));
    end
    // R3 saturation
    ev(0, 0, 0, 0, 1, 0, 0);
    for (int k = 0; k < 40; k++) ev(0, 0, 0, 0, 1, 0, 0);
    chk("R3", "rec saturate", int'(rec_byte), 255);

    // R2 / R6 / R7 / R8 sweep over every reachable transmit counter value
    for (int v = 0; v < 264; v++) begin
      do_reset();
      if (v % 8 != 0) begin
        ev(1, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 8 - v % 8; k++) ev(0, 0, 1, 0, 0, 0, 0);
      end
      for (int k = 0; k < v / 8; k++) ev(1, 0, 0, 0, 0, 0, 0);
      chk("R8", "tec low byte", int'(tec_byte), v % 256);
      chk("R7", "bus_off entry", int'(bus_off), int'(v > 255));
      check_all("R6");
      if (v > 255) begin
        ev(1, 1, 1, 1, 1, 1, 0);
        chk("R7", "frozen tec", int'(tec_byte), v % 256);
        check_all("R7 frozen");
        ev(1, 0, 0, 0, 0, 0, 1);
        check_all("R7 recover");
        chk("R7", "recover tec", int'(tec_byte), 0);
      end else begin
        ev(0, 0, 1, 0, 0, 0, 0);
        chk("R2", "tec decrement", int'(tec_byte), (v > 0) ? v - 1 : 0);
      end
    end

    // Mixed pseudo-random streams in four event densities
    for (int ph = 0; ph < 4; ph++) begin
      do_reset();
      for (int c = 0; c < 3000; c++) begin
        int r;
        bit tn, ts, tk, rn, rs, rk, rc;
        r  = $urandom;
        tn = (r % 7) < (ph + 1);
        ts = ((r >> 3) % 11) == 0;
        tk = ((r >> 7) % 3) != 0;
        rn = ((r >> 9) % 5) < ph;
        rs = ((r >> 12) % 13) == 0;
        rk = ((r >> 16) % 3) != 0;
        rc = ((r >> 20) % 17) == 0;
        ev(tn, ts, tk, rn, rs, rk, rc);
        check_all("R2 R3 R5 R6 R7");
      end
    end

    // R9 / R10 diagnosis byte
    do_reset();
    diag_we = 1; diag_wr_mode = 2'b11; rx_pin = 1;
    @(posedge clk); @(negedge clk);
    diag_we = 0; diag_wr_mode = 2'b00;
    chk("R9", "diag write 11", int'(diag_rdata), 8'h0B);
    chk("R9", "mode outputs", int'({silent_mode, loopback_mode}), 3);
    sample_bit = 1; sample_strobe = 1;
    @(posedge clk); @(negedge clk);
    sample_strobe = 0; sample_bit = 0; rx_pin = 0;
    chk("R10", "sample captured", int'(diag_rdata), 8'h0F);
    @(posedge clk); @(negedge clk);
    chk("R10", "sample held, pin low", int'(diag_rdata), 8'h07);
    diag_we = 1; diag_wr_mode = 2'b10;
    @(posedge clk); @(negedge clk);
    diag_we = 0;
    chk("R9", "diag write 10", int'(diag_rdata), 8'h06);
    diag_wr_mode = 2'b01;
    @(posedge clk); @(negedge clk);
    chk("R9", "no write without we", int'({silent_mode, loopback_mode}), 2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule